// File: doc/BRIEF.md
# Four-Rail Power Enable Sequencer

This block raises and lowers four power-rail enables, A to D, in a staged order driven by one request input. While the request is high the rails come up one at a time, A first and D last. When the request drops, the rails go down one at a time. A static mode input sets the shutdown order. In reverse mode the last rail to come up is the first to go down. In forward mode the rails shut down in the same order they came up.

The step between two rail changes is measured on a tick input rather than on an analog timer. Each single-cycle tick pulse is one timing cycle, and one step takes N ticks, where N is 2, 4, 8 or 16. The request passes through a two-flop synchronizer. The mode and the N selection are captured when a sequence starts, and the captured values hold until that sequence ends.

A sequence that has started always runs to completion. When it finishes, the block compares the request level with the state it has reached. If they disagree, the opposite sequence starts. Three status outputs report whether a sequence is running, whether all rails are up, and whether all rails are down.

Top module: `pwrseq_top`

## Requirements
- R1: While synchronous reset is held, and in the cycle after it, rail_en is 4'b0000, all_off is 1, busy is 0 and power_good is 0.
- R2: Once the synchronized request is seen high in the all-off state, a rise sequence starts. Rail bit 0 (A) goes high on the Nth tick counted in that sequence. Bits 1, 2 and 3 (B, C, D) each go high N ticks after the previous bit.
- R3: div_sel selects the ticks per step: 2'b00 gives N=2, 2'b01 gives N=4, 2'b10 gives N=8 and 2'b11 gives N=16. Fewer than N ticks since the last change leave rail_en unchanged.
- R4: With off_fwd=0 (reverse), a fall sequence clears bit 3, then bit 2, then bit 1, then bit 0. Each bit clears N ticks after the previous one, and the first clears N ticks after the fall sequence starts.
- R5: With off_fwd=1 (forward), a fall sequence clears bit 0, then bit 1, then bit 2, then bit 3, with the same N-tick spacing.
- R6: At most one rail_en bit changes in any clock cycle. A change appears only in the cycle after a tick pulse.
- R7: A change of on_req during a sequence does not alter that sequence. At the end of the sequence, if the request level disagrees with the state reached, the opposite sequence starts at once.
- R8: off_fwd and div_sel are captured when a sequence starts. Changing them during the sequence has no effect on its order or its step length.
- R9: busy is high during a sequence. power_good is high only when idle with all rails high. all_off is high only when idle with all rails low. Exactly one of the three is high at any time.
- R10: Tick pulses while idle, in either the all-on or the all-off state, do not change rail_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| on_req | input | 1 | Power request, asynchronous to clk |
| tick | input | 1 | Timing-cycle pulse, one clock wide |
| off_fwd | input | 1 | Shutdown order: 0 reverse (D..A), 1 forward (A..D) |
| div_sel | input | 2 | Ticks per step: 00=2, 01=4, 10=8, 11=16 |
| rail_en | output | 4 | Rail enables, bit 0 = A to bit 3 = D |
| busy | output | 1 | A rise or fall sequence is running |
| power_good | output | 1 | Idle with all rails on |
| all_off | output | 1 | Idle with all rails off |

## Verification
The bound checker watches every cycle for these properties: one rail bit at most changing per clock, changes only after a tick, status flags that agree with the rail vector, exactly one status flag high, and the reset state. Only the bench's scenarios can show the ordering of each sequence, the exact tick count for each div_sel code, and the capture of mode and step length at sequence start. The same holds for ignoring request changes mid-sequence and the automatic reverse sequence that follows.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_RISE = 2'd1,
        PH_GOOD = 2'd2,
        PH_FALL = 2'd3
    } phase_e;

    // ticks per step minus one, N = 2 << sel
    function automatic int step_limit(input int sel);
        return (2 << sel) - 1;
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pwrseq_step_timer.sv
module pwrseq_step_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        fire  = run && tick && (cnt_q == limit);
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (fire) cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int RAILS = 4,
    parameter int SEL_W = 2,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             on_lvl,
    input  logic             fwd_sel,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             fire,
    output logic             run,
    output logic [CNT_W-1:0] limit,
    output logic [RAILS-1:0] rails,
    output logic             busy,
    output logic             power_good,
    output logic             all_off
);
    localparam int STEP_W = $clog2(RAILS);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(RAILS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [RAILS-1:0]  rails;
        logic [STEP_W-1:0] step;
        logic              fwd;
        logic [CNT_W-1:0]  lim;
    } seq_t;

    seq_t st_d, st_q;
    logic [STEP_W-1:0] fall_idx;

    always_comb begin
        st_d     = st_q;
        fall_idx = st_q.fwd ? st_q.step : (LAST - st_q.step);
        case (st_q.phase)
            PH_OFF: if (on_lvl) begin
                st_d.phase = PH_RISE;
                st_d.step  = '0;
                st_d.fwd   = fwd_sel;
                st_d.lim   = CNT_W'(step_limit(int'(div_sel)));
            end
            PH_RISE: if (fire) begin
                st_d.rails[st_q.step] = 1'b1;
                if (st_q.step == LAST) st_d.phase = PH_GOOD;
                else                   st_d.step  = st_q.step + 1'b1;
            end
            PH_GOOD: if (!on_lvl) begin
                st_d.phase = PH_FALL;
                st_d.step  = '0;
                st_d.fwd   = fwd_sel;
                st_d.lim   = CNT_W'(step_limit(int'(div_sel)));
            end
            PH_FALL: if (fire) begin
                st_d.rails[fall_idx] = 1'b0;
                if (st_q.step == LAST) st_d.phase = PH_OFF;
                else                   st_d.step  = st_q.step + 1'b1;
            end
            default: st_d.phase = PH_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_OFF;
            st_q.rails <= '0;
            st_q.step  <= '0;
            st_q.fwd   <= 1'b0;
            st_q.lim   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run        = (st_q.phase == PH_RISE) || (st_q.phase == PH_FALL);
    assign limit      = st_q.lim;
    assign rails      = st_q.rails;
    assign busy       = run;
    assign power_good = (st_q.phase == PH_GOOD);
    assign all_off    = (st_q.phase == PH_OFF);
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top #(
    parameter int RAILS = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             on_req,
    input  logic             tick,
    input  logic             off_fwd,
    input  logic [SEL_W-1:0] div_sel,
    output logic [RAILS-1:0] rail_en,
    output logic             busy,
    output logic             power_good,
    output logic             all_off
);
    localparam int MAX_N = 2 << ((1 << SEL_W) - 1);
    localparam int CNT_W = $clog2(MAX_N);

    logic             on_lvl;
    logic             run;
    logic             fire;
    logic [CNT_W-1:0] limit;

    pwrseq_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst(rst), .async_in(on_req), .sync_out(on_lvl)
    );

    pwrseq_step_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst(rst), .run(run), .tick(tick),
        .limit(limit), .fire(fire)
    );

    pwrseq_fsm #(.RAILS(RAILS), .SEL_W(SEL_W), .CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst(rst), .on_lvl(on_lvl), .fwd_sel(off_fwd),
        .div_sel(div_sel), .fire(fire), .run(run), .limit(limit),
        .rails(rail_en), .busy(busy), .power_good(power_good),
        .all_off(all_off)
    );
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
    parameter int RAILS = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [RAILS-1:0] rail_en,
    input logic             busy,
    input logic             power_good,
    input logic             all_off
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rail_en == '0) && all_off && !busy && !power_good);

    // R6
    single_change_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(rail_en ^ $past(rail_en)) <= 1);

    // R6
    change_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (rail_en != $past(rail_en)) |-> $past(tick));

    // R9
    good_all_high_chk: assert property (@(posedge clk) disable iff (rst)
        power_good |-> (rail_en == '1));

    // R9
    off_all_low_chk: assert property (@(posedge clk) disable iff (rst)
        all_off |-> (rail_en == '0));

    // R9
    one_status_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({busy, power_good, all_off}) == 1);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(power_good) || $past(all_off)) |-> (rail_en == $past(rail_en)));
endmodule

bind pwrseq_top pwrseq_chk #(.RAILS(RAILS)) chk_i (
    .clk(clk), .rst(rst), .tick(tick), .rail_en(rail_en),
    .busy(busy), .power_good(power_good), .all_off(all_off)
);

// File: tb/pwrseq_top_tb_top.sv
`timescale 1ns/1ps
module pwrseq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       on_req = 1'b0;
    logic       tick = 1'b0;
    logic       off_fwd = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic [3:0] rail_en;
    logic       busy, power_good, all_off;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwrseq_top dut_i (
        .clk(clk), .rst(rst), .on_req(on_req), .tick(tick),
        .off_fwd(off_fwd), .div_sel(div_sel), .rail_en(rail_en),
        .busy(busy), .power_good(power_good), .all_off(all_off)
    );

    // {off_fwd, div_sel, N}
    localparam logic [7:0] VEC [0:5] = '{
        {1'b0, 2'd0, 5'd2},
        {1'b1, 2'd0, 5'd2},
        {1'b0, 2'd1, 5'd4},
        {1'b1, 2'd2, 5'd8},
        {1'b0, 2'd3, 5'd16},
        {1'b1, 2'd3, 5'd16}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [3:0] expect_rails(input bit up, input bit fwd, input int s);
        if (up)       return 4'((1 << (s + 1)) - 1);
        else if (fwd) return 4'((4'hF << (s + 1)) & 4'hF);
        else          return 4'(4'hF >> (s + 1));
    endfunction

    // walk one sequence, checking hold before each step and pattern after
    task automatic walk(input bit up, input bit fwd, input int n, input string req);
        logic [3:0] prev;
        for (int s = 0; s < 4; s++) begin
            prev = rail_en;
            ticks(n - 1);
            check("R3 hold", int'(rail_en), int'(prev));
            check("R9 busy", int'(busy), 1);
            ticks(1);
            check(req, int'(rail_en), int'(expect_rails(up, fwd, s)));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        // R1 reset state
        check("R1 rail_en", int'(rail_en), 0);
        check("R1 status", int'({busy, power_good, all_off}), 3'b001);
        rst = 1'b0;
        idle(2);
        check("R1 after release", int'({rail_en, all_off}), 5'b00001);

        // R10 ticks while off
        ticks(20);
        check("R10 off idle", int'(rail_en), 0);

        // table walk: R2 R3 R4 R5
        for (int v = 0; v < 6; v++) begin
            off_fwd = VEC[v][7];
            div_sel = VEC[v][6:5];
            on_req  = 1'b1;
            idle(4);
            walk(1'b1, 1'b0, int'(VEC[v][4:0]), "R2 rise");
            idle(1);
            check("R9 good", int'({busy, power_good, all_off}), 3'b010);
            ticks(20);
            check("R10 good idle", int'(rail_en), 4'hF);
            on_req = 1'b0;
            idle(4);
            walk(1'b0, VEC[v][7], int'(VEC[v][4:0]),
                 VEC[v][7] ? "R5 forward" : "R4 reverse");
            idle(1);
            check("R9 off", int'({busy, power_good, all_off}), 3'b001);
        end

        // R8: settings captured at start of each sequence
        off_fwd = 1'b0; div_sel = 2'd0;
        on_req = 1'b1;
        idle(4);
        div_sel = 2'd3;
        walk(1'b1, 1'b0, 2, "R8 rise step length");
        off_fwd = 1'b1; div_sel = 2'd1;
        on_req = 1'b0;
        idle(4);
        off_fwd = 1'b0; div_sel = 2'd0;
        walk(1'b0, 1'b1, 4, "R8 fall order and length");
        idle(1);

        // R7: request dropped mid-rise, then auto fall
        off_fwd = 1'b0; div_sel = 2'd0;
        on_req = 1'b1;
        idle(4);
        ticks(2);
        check("R7 first rail", int'(rail_en), 4'h1);
        on_req = 1'b0;
        idle(4);
        ticks(6);
        check("R7 rise completes", int'(rail_en), 4'hF);
        idle(1);
        check("R7 fall begins", int'(busy), 1);
        walk(1'b0, 1'b0, 2, "R7 auto fall");
        idle(2);
        check("R7 stays off", int'({rail_en, all_off}), 5'b00001);

        // R7: request raised mid-fall, then auto rise
        on_req = 1'b1;
        idle(4);
        walk(1'b1, 1'b0, 2, "R7 rise");
        on_req = 1'b0;
        idle(4);
        ticks(2);
        on_req = 1'b1;
        idle(4);
        ticks(6);
        check("R7 fall completes", int'(rail_en), 0);
        idle(1);
        check("R7 rise begins", int'(busy), 1);
        walk(1'b1, 1'b0, 2, "R7 auto rise");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule